// File: doc/BRIEF.md
# Register-List Load Sequencer

This block loads a chosen group of registers from consecutive memory locations. A mask picks the registers. The low half of the mask selects data registers and the high half selects address registers. The block walks the selected registers in a fixed order: data registers first, then address registers, each file from index zero upward. It issues one memory read per selected register. Each returned value goes out on a register write port, tagged with the mask-bit position it belongs to.

When the list is finished, the block reports the address that follows the last transfer, together with a one-cycle done pulse. A post-increment addressing mode uses this value to update its base register. A size input chooses word transfers or long transfers. Word transfers step the address by 2, and each 16-bit value is sign-extended to the full register width. Long transfers step the address by 4 and load the full value.

The memory side has two channels, a request channel and a response channel, and both use valid/ready. A request holds its valid, address and everything else steady until ready is seen. Only one read is ever outstanding. Response ready is high only while the block waits for that one read, so the memory may hold a response back for any number of cycles. The start strobe, mask, base address, size select, busy flag, done pulse and final address are plain control and status pins.

Top module: `reglist_loader`

## Requirements
- R1: The register index presented with each write equals the mask-bit position of that register. Positions below FILE_REGS name data registers 0 upward. Positions from FILE_REGS upward name address registers 0 upward, so the index MSB set means the address file.
- R2: Selected registers are written in ascending mask-bit order, and bits that are clear in the mask produce no write.
- R3: The first read goes to the start address. Each later read goes 2 bytes higher in word mode (size select 0) or 4 bytes higher in long mode (size select 1), with addresses wrapping modulo 2^ADDR_W.
- R4: The number of read requests accepted and register writes made equals the number of set mask bits.
- R5: One cycle after the final register write, done pulses for exactly one cycle and the final-address output shows start + count × step. The final address holds that value until the next transfer ends.
- R6: In word mode the written data is the low 16 bits of the response, sign-extended from bit 15. In long mode it is the response unchanged.
- R7: A start with an all-zero mask makes no request and pulses done the cycle after the strobe, with the final address equal to the start address.
- R8: A start strobe that arrives while busy is high is ignored. The list, addresses and data of the running transfer are unchanged, and no further transfer follows.
- R9: Once a request is valid, it stays valid with a stable address until ready is seen. Response ready is high only while one accepted read is awaiting its data, and never while a request is valid.
- R10: After reset the block is idle, with busy, request valid, register write and done all low.
- R11: After any register write that is not the last, the next request is valid in the very next cycle, whatever the gap of clear mask bits in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a transfer (taken only when idle) |
| mask_i | input | 2*FILE_REGS | Register selection mask |
| base_addr_i | input | ADDR_W | Start address |
| long_i | input | 1 | 1 = long transfers, 0 = word transfers |
| busy_o | output | 1 | Transfer in progress |
| req_valid_o | output | 1 | Read request valid |
| req_ready_i | input | 1 | Memory accepts the request |
| req_addr_o | output | ADDR_W | Read address |
| rsp_valid_i | input | 1 | Read data valid |
| rsp_ready_o | output | 1 | Block accepts read data |
| rsp_data_i | input | DATA_W | Read data |
| reg_we_o | output | 1 | Register write enable |
| reg_idx_o | output | $clog2(2*FILE_REGS) | Mask-bit position of the written register |
| reg_wdata_o | output | DATA_W | Register write data |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| end_addr_o | output | ADDR_W | Address following the last transfer |

## Verification
The bench builds the block with FILE_REGS=2 and ADDR_W=16. This gives a four-bit mask, so all sixteen masks can be swept in both sizes. Each mask is run from a low base and from a base just below the top of the address space, which brings address wrap and both sign cases of word data within reach. Each run uses a different memory back-pressure pattern and response latency. Some runs fire a stray start in mid-transfer.

// File: rtl/reglist_pkg.sv
package reglist_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT
  } seq_state_e;
endpackage

// File: rtl/mask_pick.sv
// Lowest-set-bit picker: index of the next register still pending.
module mask_pick #(
  parameter int W  = 16,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  pend_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  logic [W-1:0] below_clear;
  logic [W-1:0] first_hot;

  assign below_clear[0] = 1'b1;
  for (genvar g = 1; g < W; g++) begin : g_chain
    assign below_clear[g] = below_clear[g-1] & ~pend_i[g-1];
  end
  assign first_hot = pend_i & below_clear;

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < W; i++) begin
      if (first_hot[i]) idx_o = idx_o | IW'(i);
    end
  end
  assign any_o = |pend_i;
endmodule

// File: rtl/load_extend.sv
// Widens a loaded value: sign-extends word data, passes long data through.
module load_extend #(
  parameter int DATA_W = 32,
  parameter int WORD_W = 16
) (
  input  logic              long_i,
  input  logic [DATA_W-1:0] raw_i,
  output logic [DATA_W-1:0] ext_o
);
  logic [DATA_W-1:0] word_ext;
  if (DATA_W > WORD_W) begin : g_wide
    assign word_ext = {{(DATA_W-WORD_W){raw_i[WORD_W-1]}}, raw_i[WORD_W-1:0]};
  end else begin : g_flat
    assign word_ext = raw_i;
  end
  assign ext_o = long_i ? raw_i : word_ext;
endmodule

// File: rtl/reglist_loader.sv
module reglist_loader
  import reglist_pkg::*;
#(
  parameter int FILE_REGS = 8,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int WORD_W    = 16,
  localparam int MASK_W   = 2 * FILE_REGS,
  localparam int IDX_W    = $clog2(MASK_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic              long_i,
  output logic              busy_o,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [ADDR_W-1:0] req_addr_o,
  input  logic              rsp_valid_i,
  output logic              rsp_ready_o,
  input  logic [DATA_W-1:0] rsp_data_i,
  output logic              reg_we_o,
  output logic [IDX_W-1:0]  reg_idx_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] end_addr_o
);
  seq_state_e        state_q;
  logic [MASK_W-1:0] pend_q;
  logic [ADDR_W-1:0] addr_q;
  logic              long_q;
  logic [IDX_W-1:0]  cur_q;
  logic              done_q;
  logic [ADDR_W-1:0] end_q;

  logic              pick_any;
  logic [IDX_W-1:0]  pick_idx;
  logic [ADDR_W-1:0] step;
  logic [ADDR_W-1:0] addr_next;
  logic [MASK_W-1:0] pend_left;

  mask_pick #(.W(MASK_W), .IW(IDX_W)) u_pick (
    .pend_i(pend_q),
    .any_o (pick_any),
    .idx_o (pick_idx)
  );

  load_extend #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_ext (
    .long_i(long_q),
    .raw_i (rsp_data_i),
    .ext_o (reg_wdata_o)
  );

  assign step      = long_q ? ADDR_W'(4) : ADDR_W'(2);
  assign addr_next = addr_q + step;
  assign pend_left = pend_q & ~(MASK_W'(1) << cur_q);

  assign busy_o      = (state_q != ST_IDLE);
  assign req_valid_o = (state_q == ST_REQ) && pick_any;
  assign req_addr_o  = addr_q;
  assign rsp_ready_o = (state_q == ST_WAIT);
  assign reg_we_o    = rsp_ready_o && rsp_valid_i;
  assign reg_idx_o   = cur_q;
  assign done_o      = done_q;
  assign end_addr_o  = end_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= '0;
      addr_q  <= '0;
      long_q  <= 1'b0;
      cur_q   <= '0;
      done_q  <= 1'b0;
      end_q   <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            pend_q <= mask_i;
            addr_q <= base_addr_i;
            long_q <= long_i;
            if (mask_i == '0) begin
              done_q <= 1'b1;
              end_q  <= base_addr_i;
            end else begin
              state_q <= ST_REQ;
            end
          end
        end
        ST_REQ: begin
          if (req_valid_o && req_ready_i) begin
            cur_q   <= pick_idx;
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (rsp_valid_i) begin
            pend_q <= pend_left;
            addr_q <= addr_next;
            if (pend_left == '0) begin
              done_q  <= 1'b1;
              end_q   <= addr_next;
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_REQ;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/reglist_loader_chk.sv
module reglist_loader_chk #(
  parameter int FILE_REGS = 8,
  parameter int ADDR_W    = 32,
  localparam int MASK_W   = 2 * FILE_REGS
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [MASK_W-1:0] mask_i,
  input logic [ADDR_W-1:0] base_addr_i,
  input logic              busy_o,
  input logic              req_valid_o,
  input logic              req_ready_i,
  input logic [ADDR_W-1:0] req_addr_o,
  input logic              rsp_ready_o,
  input logic              reg_we_o,
  input logic              done_o,
  input logic [ADDR_W-1:0] end_addr_o
);
  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_addr_o)));

  a_r9_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid_o && rsp_ready_o));

  a_r11_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |=> (req_valid_o != done_o));

  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r7_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && mask_i == '0) |=>
      (done_o && !busy_o && end_addr_o == $past(base_addr_i)));

  a_r8_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !reg_we_o) |=> busy_o);
endmodule

bind reglist_loader reglist_loader_chk #(.FILE_REGS(FILE_REGS), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .mask_i     (mask_i),
  .base_addr_i(base_addr_i),
  .busy_o     (busy_o),
  .req_valid_o(req_valid_o),
  .req_ready_i(req_ready_i),
  .req_addr_o (req_addr_o),
  .rsp_ready_o(rsp_ready_o),
  .reg_we_o   (reg_we_o),
  .done_o     (done_o),
  .end_addr_o (end_addr_o)
);

// File: tb/reglist_loader_bench.sv
module reglist_loader_bench;
  localparam int FR = 2;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int MW = 2 * FR;
  localparam int IW = $clog2(MW);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [MW-1:0] mask_i = '0;
  logic [AW-1:0] base_addr_i = '0;
  logic          long_i = 1'b0;
  logic          busy_o;
  logic          req_valid_o;
  logic          req_ready_i = 1'b0;
  logic [AW-1:0] req_addr_o;
  logic          rsp_valid_i = 1'b0;
  logic          rsp_ready_o;
  logic [DW-1:0] rsp_data_i = '0;
  logic          reg_we_o;
  logic [IW-1:0] reg_idx_o;
  logic [DW-1:0] reg_wdata_o;
  logic          done_o;
  logic [AW-1:0] end_addr_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  reglist_loader #(.FILE_REGS(FR), .ADDR_W(AW), .DATA_W(DW), .WORD_W(16)) u_reglist_loader (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mask_i(mask_i),
    .base_addr_i(base_addr_i), .long_i(long_i), .busy_o(busy_o),
    .req_valid_o(req_valid_o), .req_ready_i(req_ready_i), .req_addr_o(req_addr_o),
    .rsp_valid_i(rsp_valid_i), .rsp_ready_o(rsp_ready_o), .rsp_data_i(rsp_data_i),
    .reg_we_o(reg_we_o), .reg_idx_o(reg_idx_o), .reg_wdata_o(reg_wdata_o),
    .done_o(done_o), .end_addr_o(end_addr_o)
  );

  function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
    return {a ^ 16'h5A5A, a ^ 16'h8003};
  endfunction

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_case(input logic [MW-1:0] mask, input bit lng,
                          input logic [AW-1:0] base, input int seed, input bit poke);
    int n = 0, k = 0, reqs = 0, dly = 0, it = 0;
    int order[MW];
    bit have = 0, req_fire = 0, rsp_fire = 0, want_req = 0, seen_done = 0;
    logic [AW-1:0] lat = '0, pend_a = '0, exp_a;
    logic [AW-1:0] step = lng ? 16'd4 : 16'd2;
    logic [DW-1:0] raw, exp_d;
    for (int b = 0; b < MW; b++) if (mask[b]) begin order[n] = b; n++; end
    while (!seen_done && it < 300) begin
      @(negedge clk);
      if (rsp_fire) rsp_valid_i = 1'b0;
      if (req_fire) begin have = 1; pend_a = lat; dly = (seed + it) % 3; end
      if (have && !rsp_valid_i) begin
        if (dly == 0) begin rsp_valid_i = 1'b1; rsp_data_i = mem_word(pend_a); have = 0; end
        else dly--;
      end
      req_ready_i = ((seed + it) % 4) != 1;
      if (it == 0) begin start_i = 1; mask_i = mask; base_addr_i = base; long_i = lng; end
      else if (poke && it == 3) begin start_i = 1; mask_i = '1; base_addr_i = 16'h0; long_i = ~lng; end
      else start_i = 0;
      #1;
      if (want_req) check(req_valid_o == 1'b1, "R11 next request", DW'(req_valid_o), 1);
      want_req = 0;
      if (rsp_valid_i) check(rsp_ready_o == 1'b1, "R9 rsp ready", DW'(rsp_ready_o), 1);
      req_fire = req_valid_o && req_ready_i;
      lat = req_addr_o;
      rsp_fire = rsp_valid_i && rsp_ready_o;
      if (req_fire) begin
        exp_a = base + AW'(reqs) * step;
        check(req_addr_o == exp_a, "R3 address", DW'(req_addr_o), DW'(exp_a));
        reqs++;
      end
      if (reg_we_o) begin
        check(k < n, "R2 extra write", DW'(k), DW'(n));
        if (k < n) begin
          check(reg_idx_o == IW'(order[k]), "R1 R2 index", DW'(reg_idx_o), DW'(order[k]));
          raw = mem_word(base + AW'(k) * step);
          exp_d = lng ? raw : {{16{raw[15]}}, raw[15:0]};
          check(reg_wdata_o == exp_d, "R6 data", reg_wdata_o, exp_d);
        end
        k++;
        want_req = (k < n);
      end
      if (done_o) begin
        seen_done = 1;
        exp_a = base + AW'(n) * step;
        check(end_addr_o == exp_a, "R5 end address", DW'(end_addr_o), DW'(exp_a));
        check(k == n && reqs == n, "R4 count", DW'(k), DW'(n));
        if (n == 0) check(it == 1, "R7 empty mask timing", DW'(it), 1);
      end
      it++;
    end
    start_i = 0;
    check(seen_done, "R5 done seen", DW'(seen_done), 1);
    for (int w = 0; w < 3; w++) begin
      @(negedge clk); #1;
      if (rsp_fire) rsp_valid_i = 1'b0;
      rsp_fire = 0;
      check(!req_valid_o && !busy_o && !done_o, "R8 no follow-on", DW'(busy_o), 0);
      check(end_addr_o == base + AW'(n) * step, "R5 end hold", DW'(end_addr_o),
            DW'(base + AW'(n) * step));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(!busy_o && !req_valid_o && !reg_we_o && !done_o, "R10 reset", DW'(busy_o), 0);
    rst_n = 1'b1;
    for (int s = 0; s < 2; s++)
      for (int l = 0; l < 2; l++)
        for (int m = 0; m < (1 << MW); m++)
          run_case(MW'(m), l[0], (s == 0) ? 16'h0010 : 16'hFFFA, m * 3 + l + s,
                   $countones(MW'(m)) >= 2);
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule